// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block sits on the host side of an asynchronous 8K x 8 parallel read-only memory that has independent active-low chip-select and output-gate strobes. A synchronous client raises a request with a 13-bit address. The sequencer registers the address onto the memory bus and drops the chip strobe. It drops the output strobe a set number of cycles later. It then counts enough clock cycles to cover every access constraint of the memory, captures the byte and hands it back with a single-cycle valid pulse.

After the capture both strobes rise together. The sequencer then stays busy for a float window, so the memory has stopped driving before any new access, or any other bus driver, can begin. Each timing limit is converted into cycles as ceil(t / clock period). The speed grade, the clock period and the output-strobe lag are parameters.

Grade timings in ns (grade index: address/chip-to-data, output-to-data, float): 0: 120/65/50, 1: 150/70/50, 2: 170/70/50, 3: 200/75/55, 4: 250/100/60.

Top module: `rom_rd_seq`

## Requirements
- R1: While rst_ni is low, mem_ce_n_o and mem_oe_n_o are high, busy_o and valid_o are low and rdata_o is 0.
- R2: If req_i is high at a rising edge while busy_o is low, then after that edge mem_ce_n_o is low, busy_o is high and mem_addr_o equals the addr_i sampled at that edge.
- R3: mem_oe_n_o falls OE_LAG cycles after mem_ce_n_o falls, and it is never low while mem_ce_n_o is high.
- R4: Let A = ceil(tACC/T) and O = ceil(tOE/T). The access lasts N = max(A, OE_LAG + O) cycles. At the N-th edge after acceptance, mem_data_i is captured into rdata_o and valid_o is high for exactly one cycle.
- R5: Both strobes rise at the capture edge, and mem_addr_o does not change while mem_ce_n_o is low.
- R6: After the strobes rise, busy_o stays high for F = ceil(tOFF/T) more cycles. The next falling edge of mem_ce_n_o therefore comes at least F cycles after the rise.
- R7: req_i and addr_i have no effect while busy_o is high; a held request starts its next access only once busy_o is low.
- R8: The grade table above sets the ns limits; with the default 20 ns clock, grade 0 and OE_LAG 2 give N = 6 and F = 3.
- R9: An output-strobe lag beyond A - O lengthens the access to OE_LAG + O cycles (OE_LAG 4 gives N = 8 at grade 0).
- R10: rdata_o holds its last captured byte until the next valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Read address |
| busy_o | output | 1 | Access or float window in progress |
| valid_o | output | 1 | One-cycle pulse with returned byte |
| rdata_o | output | DATA_W | Returned byte |
| mem_addr_o | output | ADDR_W | Address to memory |
| mem_ce_n_o | output | 1 | Chip strobe, active low |
| mem_oe_n_o | output | 1 | Output strobe, active low |
| mem_data_i | input | DATA_W | Data from memory |

## Verification
Counted from the edge that accepts a request, the chip strobe is low in cycles 0 to N-1 and the output strobe in cycles OE_LAG to N-1. valid_o is high in cycle N, and busy_o is high in cycles 0 to N+F-1. The bench computes these windows from the ns limits and compares them at every falling clock edge. Its memory model returns the stored byte only after each strobe and the address have been held for their full limits, so capturing one cycle early returns a garbage byte. A second instance with a late output strobe checks the lengthened access, and the model flags any chip strobe that falls inside the float time.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACCESS, PH_FLOAT} rd_phase_e;

  function automatic int unsigned grade_acc_ns(input int unsigned g);
    case (g)
      0: return 120;
      1: return 150;
      2: return 170;
      3: return 200;
      default: return 250;
    endcase
  endfunction

  function automatic int unsigned grade_oe_ns(input int unsigned g);
    case (g)
      0: return 65;
      1, 2: return 70;
      3: return 75;
      default: return 100;
    endcase
  endfunction

  function automatic int unsigned grade_off_ns(input int unsigned g);
    case (g)
      0, 1, 2: return 50;
      3: return 55;
      default: return 60;
    endcase
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rom_rd_phase.sv
module rom_rd_phase
  import rom_rd_pkg::*;
#(
  parameter int unsigned ACC_TOTAL = 6,
  parameter int unsigned OFF_CYC   = 3,
  parameter int unsigned OE_LAG    = 2,
  parameter int unsigned CNT_W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o,
  output logic start_o,
  output logic sample_o,
  output logic oe_go_o
);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_TOTAL - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] OE_AT    = CNT_W'((OE_LAG == 0) ? 0 : OE_LAG - 1);

  rd_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             float_done;

  assign start_o    = (phase_q == PH_IDLE) && req_i;
  assign sample_o   = (phase_q == PH_ACCESS) && (cnt_q == ACC_LAST);
  assign oe_go_o    = (OE_LAG != 0) && (phase_q == PH_ACCESS) && (cnt_q == OE_AT);
  assign float_done = (phase_q == PH_FLOAT) && (cnt_q == OFF_LAST);
  assign busy_o     = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_o) phase_d = PH_ACCESS;
      end
      PH_ACCESS: if (sample_o) begin
        phase_d = PH_FLOAT;
        cnt_d   = '0;
      end
      PH_FLOAT: if (float_done) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_ACCESS_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACCESS && cnt_q != ACC_LAST) |=> (phase_q == PH_ACCESS)); // R4
  AST_FLOAT_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FLOAT && cnt_q != OFF_LAST) |=> (phase_q == PH_FLOAT)); // R6
  AST_FLOAT_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACCESS) |=> (phase_q != PH_IDLE)); // R6
endmodule

// File: rtl/rom_rd_strobe.sv
module rom_rd_strobe #(
  parameter int unsigned OE_LAG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic oe_go_i,
  input  logic sample_i,
  output logic ce_n_o,
  output logic oe_n_o
);
  logic oe_fall;

  generate
    if (OE_LAG == 0) begin : g_oe_with_ce
      assign oe_fall = start_i;
    end else begin : g_oe_late
      assign oe_fall = oe_go_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o <= 1'b1;
      oe_n_o <= 1'b1;
    end else begin
      if (sample_i) begin
        ce_n_o <= 1'b1;
        oe_n_o <= 1'b1;
      end else begin
        if (start_i) ce_n_o <= 1'b0;
        if (oe_fall) oe_n_o <= 1'b0;
      end
    end
  end

  AST_OE_INSIDE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !ce_n_o); // R3
  AST_RISE_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_o) |-> (oe_n_o && !$past(oe_n_o))); // R5
endmodule

// File: rtl/rom_rd_capture.sv
module rom_rd_capture #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic              ce_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      rdata_o    <= '0;
      valid_o    <= 1'b0;
    end else begin
      if (start_i)  mem_addr_o <= addr_i;
      if (sample_i) rdata_o    <= mem_data_i;
      valid_o <= sample_i;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && $past(!ce_n_i)) |-> $stable(mem_addr_o)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(rdata_o)); // R10
endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned GRADE  = 0,
  parameter int unsigned OE_LAG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int unsigned ACC_CYC   = ns_to_cyc(grade_acc_ns(GRADE), CLK_NS);
  localparam int unsigned OE_CYC    = ns_to_cyc(grade_oe_ns(GRADE), CLK_NS);
  localparam int unsigned OFF_CYC   = ns_to_cyc(grade_off_ns(GRADE), CLK_NS);
  localparam int unsigned ACC_TOTAL = max_u(ACC_CYC, OE_LAG + OE_CYC);
  localparam int unsigned CNT_W     = $clog2(max_u(ACC_TOTAL, OFF_CYC) + 1);

  logic start, sample, oe_go;

  rom_rd_phase #(
    .ACC_TOTAL(ACC_TOTAL), .OFF_CYC(OFF_CYC), .OE_LAG(OE_LAG), .CNT_W(CNT_W)
  ) u_phase (
    .clk_i, .rst_ni, .req_i,
    .busy_o, .start_o(start), .sample_o(sample), .oe_go_o(oe_go)
  );

  rom_rd_strobe #(.OE_LAG(OE_LAG)) u_strobe (
    .clk_i, .rst_ni,
    .start_i(start), .oe_go_i(oe_go), .sample_i(sample),
    .ce_n_o(mem_ce_n_o), .oe_n_o(mem_oe_n_o)
  );

  rom_rd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk_i, .rst_ni,
    .start_i(start), .sample_i(sample), .ce_n_i(mem_ce_n_o),
    .addr_i, .mem_data_i, .mem_addr_o, .rdata_o, .valid_o
  );

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_n_o) |-> !$past(busy_o)); // R7
  AST_VALID_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_n_o) |-> (valid_o && busy_o)); // R5
endmodule

// File: tb/tb_rom_rd_seq.sv
module tb_rom_model #(
  parameter int ACC_NS = 120,
  parameter int OE_NS  = 65,
  parameter int OFF_NS = 50
) (
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic [12:0] addr,
  output logic [7:0]  data,
  output logic        float_err
);
  longint t_ce = -1000, t_oe = -1000, t_addr = -1000, t_rise = -1000;
  bit     ferr = 1'b0;
  logic [7:0] dq = 8'hEE;

  assign data      = dq;
  assign float_err = ferr;

  always @(negedge ce_n) begin
    if ($time - t_rise < OFF_NS) ferr = 1'b1;
    t_ce = $time;
  end
  always @(negedge oe_n) t_oe = $time;
  always @(posedge ce_n or posedge oe_n) t_rise = $time;
  always @(addr) t_addr = $time;

  // evaluated at odd times, never on a clock edge
  initial begin
    #1;
    forever begin
      if (!ce_n && !oe_n && ($time - t_ce >= ACC_NS - 1) &&
          ($time - t_oe >= OE_NS - 1) && ($time - t_addr >= ACC_NS - 1))
        dq = addr[7:0] ^ {3'b000, addr[12:8]} ^ 8'h5A;
      else
        dq = 8'hEE;
      #2;
    end
  end
endmodule

module tb_rom_rd_seq;
  localparam int T_NS   = 20;
  localparam int ACC_NS = 120;
  localparam int OE_NS  = 65;
  localparam int OFF_NS = 50;
  localparam int A_CYC  = (ACC_NS + T_NS - 1) / T_NS;
  localparam int O_CYC  = (OE_NS + T_NS - 1) / T_NS;
  localparam int F_CYC  = (OFF_NS + T_NS - 1) / T_NS;
  localparam int LAG0   = 2;
  localparam int LAG1   = 4;
  localparam int N0     = (A_CYC > LAG0 + O_CYC) ? A_CYC : LAG0 + O_CYC;
  localparam int N1     = (A_CYC > LAG1 + O_CYC) ? A_CYC : LAG1 + O_CYC;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [12:0] addr_i = '0;

  logic busy[2], valid[2], ce_n[2], oe_n[2], ferr[2];
  logic [7:0] rdata[2], mdata[2];
  logic [12:0] maddr[2];

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int acc_c[2];
  bit have[2];
  logic [12:0] acc_addr[2];
  logic [7:0] last_rd[2];

  always #10 clk_i = ~clk_i;

  rom_rd_seq #(.CLK_NS(T_NS), .GRADE(0), .OE_LAG(LAG0)) dut (
    .clk_i, .rst_ni, .req_i, .addr_i,
    .busy_o(busy[0]), .valid_o(valid[0]), .rdata_o(rdata[0]),
    .mem_addr_o(maddr[0]), .mem_ce_n_o(ce_n[0]), .mem_oe_n_o(oe_n[0]), .mem_data_i(mdata[0])
  );
  tb_rom_model #(.ACC_NS(ACC_NS), .OE_NS(OE_NS), .OFF_NS(OFF_NS)) u_mem0 (
    .ce_n(ce_n[0]), .oe_n(oe_n[0]), .addr(maddr[0]), .data(mdata[0]), .float_err(ferr[0])
  );

  rom_rd_seq #(.CLK_NS(T_NS), .GRADE(0), .OE_LAG(LAG1)) dut_late (
    .clk_i, .rst_ni, .req_i, .addr_i,
    .busy_o(busy[1]), .valid_o(valid[1]), .rdata_o(rdata[1]),
    .mem_addr_o(maddr[1]), .mem_ce_n_o(ce_n[1]), .mem_oe_n_o(oe_n[1]), .mem_data_i(mdata[1])
  );
  tb_rom_model #(.ACC_NS(ACC_NS), .OE_NS(OE_NS), .OFF_NS(OFF_NS)) u_mem1 (
    .ce_n(ce_n[1]), .oe_n(oe_n[1]), .addr(maddr[1]), .data(mdata[1]), .float_err(ferr[1])
  );

  function automatic logic [7:0] rom_byte(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  function automatic int n_of(input int i);
    return (i == 0) ? N0 : N1;
  endfunction

  function automatic int lag_of(input int i);
    return (i == 0) ? LAG0 : LAG1;
  endfunction

  task automatic chk(input string tag, input int i, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s inst%0d cyc=%0d act=%0h exp=%0h", tag, i, cyc, act, exp);
    end
  endtask

  // acceptance bookkeeping: request seen while the expected busy is low
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      cyc = 0;
      for (int i = 0; i < 2; i++) begin
        have[i] = 1'b0;
        last_rd[i] = 8'h00;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit busy_pre;
        busy_pre = have[i] && (cyc - acc_c[i] < n_of(i) + F_CYC);
        if (!busy_pre && req_i) begin // R7: otherwise ignored
          have[i] = 1'b1;
          acc_c[i] = cyc + 1;
          acc_addr[i] = addr_i;
        end
      end
      cyc++;
    end
  end

  always @(negedge clk_i) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_ni) begin
        chk("R1 ce_n", i, 32'(ce_n[i]), 32'd1);
        chk("R1 oe_n", i, 32'(oe_n[i]), 32'd1);
        chk("R1 busy", i, 32'(busy[i]), 32'd0);
        chk("R1 valid", i, 32'(valid[i]), 32'd0);
        chk("R1 rdata", i, 32'(rdata[i]), 32'd0);
      end else begin
        int rel, n;
        bit e_ce, e_oe, e_val, e_busy;
        rel = have[i] ? cyc - acc_c[i] : 1 << 20;
        n = n_of(i);
        e_ce   = have[i] && rel < n;
        e_oe   = have[i] && rel >= lag_of(i) && rel < n;
        e_val  = have[i] && rel == n;
        e_busy = have[i] && rel < n + F_CYC;
        chk((i == 0) ? "R2 ce_n" : "R9 ce_n", i, 32'(ce_n[i]), 32'(!e_ce));
        chk("R3 oe_n", i, 32'(oe_n[i]), 32'(!e_oe));
        chk((i == 0) ? "R4 valid" : "R9 valid", i, 32'(valid[i]), 32'(e_val));
        chk("R6 R8 busy", i, 32'(busy[i]), 32'(e_busy));
        if (e_ce) chk("R2 R5 R7 addr", i, 32'(maddr[i]), 32'(acc_addr[i]));
        if (e_val) last_rd[i] = rom_byte(acc_addr[i]);
        chk("R4 R10 rdata", i, 32'(rdata[i]), 32'(last_rd[i]));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
    #2;
  endtask

  task automatic single_read(input logic [12:0] a);
    addr_i = a;
    req_i = 1'b1;
    step(1);
    req_i = 1'b0;
    addr_i = ~a;
    step(N1 + F_CYC + 4);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk_i);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    join_none
    step(3);
    rst_ni = 1'b1;
    step(2);
    // R2 R4 R8: single reads at corner addresses
    single_read(13'h0000);
    single_read(13'h1FFF);
    single_read(13'h1555);
    single_read(13'h0AAA);
    // R6 R7: held request, address churns every cycle
    req_i = 1'b1;
    for (int k = 0; k < 40; k++) begin
      addr_i = 13'(k * 97 + 5);
      step(1);
    end
    req_i = 1'b0;
    step(N1 + F_CYC + 4);
    // R1: reset in the middle of an access
    addr_i = 13'h0123;
    req_i = 1'b1;
    step(1);
    req_i = 1'b0;
    step(3);
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(F_CYC + 2);
    single_read(13'h1ABC);
    for (int i = 0; i < 2; i++) chk("R6 float", i, 32'(ferr[i]), 32'd0);
    finish_run();
  end
endmodule